// File: doc/BRIEF.md
# Parallel ADC Read Controller

This block sits on the host side of a 12-bit sampling converter that has a parallel output. The converter has an active-low conversion-start strobe, a busy flag that is low while it converts, an active-low chip select and an active-low read enable. Each sample request makes the controller lower chip select and pulse the start strobe after a set setup time. It then waits for busy to rise and collects the 12-bit two's-complement result. The result appears on a one-cycle valid strobe with a signed data word, and the word holds until the next capture.

Two capture styles exist. In shared-bus mode the read enable is pulsed low after busy rises, and the word is taken on the last cycle of that pulse. In always-enabled mode the read enable stays low for the whole transaction, and the word is taken in the cycle busy rises. The capture style is sampled while reset is held. The setup time, strobe width, read access time, minimum start-to-start period and conversion timeout are all counts of clock cycles. Requests that arrive too early are counted and served later. A conversion that never ends raises a one-cycle error.

Top module: `parAdcReader`

## Requirements
- R1: While reset is held and in the first cycle after it, adcCsN, adcConvN and adcRdN are high, resValid and timeoutErr are low, and resData is zero.
- R2: adcCsN goes low exactly CS_SETUP_CYC cycles before adcConvN falls. adcConvN then stays low for exactly START_LOW_CYC cycles before it returns high.
- R3: A conversion starts only after a sampleReq pulse. Each request pulse is counted, up to 2**PEND_W-1 requests at once, and each counted request later produces its own conversion.
- R4: The falling edges of adcConvN for consecutive conversions are at least PERIOD_CYC cycles apart. When requests are waiting, the gap is exactly PERIOD_CYC.
- R5: In always-enabled mode (modeSel=0 at reset), adcRdN is low whenever adcCsN is low. adcData is captured in the first cycle that adcBusy is seen high after being low during the wait. resValid pulses in the next cycle, and adcCsN returns high with it.
- R6: In shared-bus mode (modeSel=1 at reset), adcRdN goes low for exactly RD_ACCESS_CYC cycles, starting the cycle after the busy rise is seen. adcData is captured on the last of those cycles. resValid pulses RD_ACCESS_CYC+1 cycles after the rise is seen.
- R7: resData is the captured word read as a 12-bit two's-complement number (12'h800 is -2048, 12'hFFF is -1). It changes only in a cycle where resValid is high.
- R8: If adcBusy has not risen by TIMEOUT_CYC cycles after adcConvN falls, timeoutErr pulses for one cycle at that point. No resValid is produced, and adcCsN returns high in the same cycle.
- R9: modeSel is sampled only while rstN is low. Changes to it at any other time have no effect on the capture style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also samples modeSel |
| modeSel | input | 1 | Capture style: 0 always-enabled, 1 shared-bus read strobe |
| sampleReq | input | 1 | One-cycle request for one conversion |
| adcBusy | input | 1 | Converter busy flag, low while converting |
| adcData | input | 12 | Converter parallel data bus |
| adcCsN | output | 1 | Chip select, active low |
| adcConvN | output | 1 | Conversion start strobe, active low |
| adcRdN | output | 1 | Read enable, active low |
| resValid | output | 1 | One-cycle strobe for a new result |
| resData | output | 12 | Signed result word |
| timeoutErr | output | 1 | One-cycle strobe when a conversion times out |

## Verification
The assertions assume that adcBusy and adcData change only away from the active edge. They also assume that a conversion lasts longer than the start strobe, so the busy rise never comes while adcConvN is still low. The stimulus respects both points: a converter model in the bench drives busy and data on the falling clock edge, and it is given conversion times of about 130 cycles against a 4-cycle strobe. In shared-bus mode the model drives the real word only after the read enable has been low for two cycles, and in always-enabled mode it drives the real word only once busy is high. At any other time it puts a poison value on the bus. Because of this, a capture taken in the wrong cycle shows up as a wrong result.

// File: rtl/parAdcReader_pkg.sv
package parAdcReader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_WAIT,
    ST_READ
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic timeout;
  } dpStrobe_t;

endpackage

// File: rtl/parAdcReaderCtrl.sv
module parAdcReaderCtrl
  import parAdcReader_pkg::*;
#(
  parameter int CS_SETUP_CYC  = 2,
  parameter int START_LOW_CYC = 4,
  parameter int RD_ACCESS_CYC = 6,
  parameter int PERIOD_CYC    = 160,
  parameter int TIMEOUT_CYC   = 160,
  parameter int PEND_W        = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeSel,
  input  logic      sampleReq,
  input  logic      busyRise,
  output logic      csN,
  output logic      convN,
  output logic      rdN,
  output dpStrobe_t strobe
);

  localparam int CNT_MAX = (CS_SETUP_CYC > START_LOW_CYC)
                         ? ((CS_SETUP_CYC > RD_ACCESS_CYC) ? CS_SETUP_CYC : RD_ACCESS_CYC)
                         : ((START_LOW_CYC > RD_ACCESS_CYC) ? START_LOW_CYC : RD_ACCESS_CYC);
  localparam int CNT_W  = $clog2(CNT_MAX + 1);
  localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int GAP_W  = $clog2(PERIOD_CYC + 1);
  localparam int GAP_OK = PERIOD_CYC - 1 - CS_SETUP_CYC;

  localparam logic [CNT_W-1:0]  SETUP_LAST = CNT_W'(CS_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0]  STROBE_LAST = CNT_W'(START_LOW_CYC - 1);
  localparam logic [CNT_W-1:0]  READ_LAST  = CNT_W'(RD_ACCESS_CYC - 1);
  localparam logic [TMO_W-1:0]  TMO_LAST   = TMO_W'(TIMEOUT_CYC - 1);
  localparam logic [GAP_W-1:0]  GAP_SAT    = GAP_W'(PERIOD_CYC);
  localparam logic [PEND_W-1:0] PEND_MAX   = '1;

  ctrlState_e        state, nextState;
  logic [CNT_W-1:0]  cnt, cntD;
  logic [TMO_W-1:0]  tmoCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [PEND_W-1:0] pendCnt;
  logic              modeQ;
  logic              gapOk;
  logic              grant, convStart, capture, tmoHit;

  assign gapOk = (int'(gapCnt) >= GAP_OK);

  // capture style is fixed while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= modeSel;
  end

  always_comb begin
    nextState = state;
    cntD      = cnt + 1'b1;
    grant     = 1'b0;
    convStart = 1'b0;
    capture   = 1'b0;
    tmoHit    = 1'b0;
    case (state)
      ST_IDLE: begin
        cntD = '0;
        if (pendCnt != '0 && gapOk) begin
          nextState = ST_SETUP;
          grant     = 1'b1;
        end
      end
      ST_SETUP: begin
        if (cnt == SETUP_LAST) begin
          nextState = ST_CONV;
          cntD      = '0;
          convStart = 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt == STROBE_LAST) begin
          nextState = ST_WAIT;
          cntD      = '0;
        end
      end
      ST_WAIT: begin
        cntD = '0;
        if (busyRise) begin
          if (modeQ) begin
            nextState = ST_READ;
          end else begin
            nextState = ST_IDLE;
            capture   = 1'b1;
          end
        end else if (tmoCnt == TMO_LAST) begin
          nextState = ST_IDLE;
          tmoHit    = 1'b1;
        end
      end
      ST_READ: begin
        if (cnt == READ_LAST) begin
          nextState = ST_IDLE;
          cntD      = '0;
          capture   = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      tmoCnt <= '0;
      gapCnt <= GAP_SAT;
      csN    <= 1'b1;
      convN  <= 1'b1;
      rdN    <= 1'b1;
    end else begin
      state <= nextState;
      cnt   <= cntD;
      if (convStart)                               tmoCnt <= '0;
      else if (state == ST_CONV || state == ST_WAIT) tmoCnt <= tmoCnt + 1'b1;
      if (convStart)              gapCnt <= '0;
      else if (gapCnt != GAP_SAT) gapCnt <= gapCnt + 1'b1;
      csN   <= (nextState == ST_IDLE);
      convN <= (nextState != ST_CONV);
      rdN   <= modeQ ? (nextState != ST_READ) : (nextState == ST_IDLE);
    end
  end

  // pending request counter: saturating, one decrement per conversion start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else if (sampleReq && !convStart && pendCnt != PEND_MAX) begin
      pendCnt <= pendCnt + 1'b1;
    end else if (convStart && !sampleReq) begin
      pendCnt <= pendCnt - 1'b1;
    end
  end

  assign strobe.capture = capture;
  assign strobe.timeout = tmoHit;

  // ---------------- checks ----------------
  localparam int CSR_W = $clog2(CS_SETUP_CYC + 2);
  logic [CNT_W-1:0] lowRun;
  logic [CSR_W-1:0] csRun;
  logic [GAP_W-1:0] startAge;
  logic             convNPrev;
  logic             convFell;

  assign convFell = !convN && convNPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun    <= '0;
      csRun     <= '0;
      startAge  <= GAP_SAT;
      convNPrev <= 1'b1;
    end else begin
      convNPrev <= convN;
      lowRun    <= convN ? '0 : ((lowRun == CNT_W'(CNT_MAX)) ? lowRun : lowRun + 1'b1);
      csRun     <= csN ? '0 : ((csRun == CSR_W'(CS_SETUP_CYC + 1)) ? csRun : csRun + 1'b1);
      if (convFell)                 startAge <= GAP_W'(1);
      else if (startAge != GAP_SAT) startAge <= startAge + 1'b1;
    end
  end

  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convN) |-> $past(lowRun) == STROBE_LAST);

  // R2
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    convFell |-> csRun == CSR_W'(CS_SETUP_CYC));

  // R3
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(pendCnt) != '0);

  // R4
  start_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    convFell |-> int'(startAge) >= PERIOD_CYC);

  // R6
  read_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && !rdN) |-> (!csN && convN));

endmodule

// File: rtl/parAdcReaderData.sv
module parAdcReaderData
  import parAdcReader_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     adcBusy,
  input  logic [DATA_W-1:0]        adcData,
  input  dpStrobe_t                strobe,
  output logic                     busyRise,
  output logic                     resValid,
  output logic signed [DATA_W-1:0] resData,
  output logic                     timeoutErr
);

  logic busyQ;

  assign busyRise = adcBusy && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b1;
      resValid   <= 1'b0;
      resData    <= '0;
      timeoutErr <= 1'b0;
    end else begin
      busyQ      <= adcBusy;
      resValid   <= strobe.capture;
      timeoutErr <= strobe.timeout;
      if (strobe.capture) resData <= $signed(adcData);
    end
  end

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resData) |-> resValid);

  // R8
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !resValid);

endmodule

// File: rtl/parAdcReader.sv
module parAdcReader
  import parAdcReader_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int CS_SETUP_CYC  = 2,
  parameter int START_LOW_CYC = 4,
  parameter int RD_ACCESS_CYC = 6,
  parameter int PERIOD_CYC    = 160,
  parameter int TIMEOUT_CYC   = 160,
  parameter int PEND_W        = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeSel,
  input  logic                     sampleReq,
  input  logic                     adcBusy,
  input  logic [DATA_W-1:0]        adcData,
  output logic                     adcCsN,
  output logic                     adcConvN,
  output logic                     adcRdN,
  output logic                     resValid,
  output logic signed [DATA_W-1:0] resData,
  output logic                     timeoutErr
);

  dpStrobe_t strobe;
  logic      busyRise;

  parAdcReaderCtrl #(
    .CS_SETUP_CYC (CS_SETUP_CYC),
    .START_LOW_CYC(START_LOW_CYC),
    .RD_ACCESS_CYC(RD_ACCESS_CYC),
    .PERIOD_CYC   (PERIOD_CYC),
    .TIMEOUT_CYC  (TIMEOUT_CYC),
    .PEND_W       (PEND_W)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .sampleReq(sampleReq),
    .busyRise (busyRise),
    .csN      (adcCsN),
    .convN    (adcConvN),
    .rdN      (adcRdN),
    .strobe   (strobe)
  );

  parAdcReaderData #(
    .DATA_W(DATA_W)
  ) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .adcBusy   (adcBusy),
    .adcData   (adcData),
    .strobe    (strobe),
    .busyRise  (busyRise),
    .resValid  (resValid),
    .resData   (resData),
    .timeoutErr(timeoutErr)
  );

  // R5
  always_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && adcRdN) |-> adcCsN);

endmodule

// File: tb/parAdcReader_test.sv
`timescale 1ns/1ps
module parAdcReader_test;

  localparam int CS  = 2;
  localparam int SL  = 4;
  localparam int RD  = 6;
  localparam int PER = 160;
  localparam int TMO = 160;
  localparam int PMAX = 3;
  localparam int GAP_OK = PER - 1 - CS;
  localparam logic [11:0] POISON = 12'h5C3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic sampleReq = 1'b0;
  logic adcBusy = 1'b1;
  logic [11:0] adcData = POISON;
  logic adcCsN, adcConvN, adcRdN, resValid, timeoutErr;
  logic signed [11:0] resData;

  parAdcReader uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sampleReq(sampleReq),
    .adcBusy(adcBusy), .adcData(adcData), .adcCsN(adcCsN), .adcConvN(adcConvN),
    .adcRdN(adcRdN), .resValid(resValid), .resData(resData), .timeoutErr(timeoutErr)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycle = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int   mPend, mGap, mStep, mRiseAt;
  bit   mAct, mMode, mPrevBusy, mRise, mDec, mDone, mGrant;
  logic expValid = 1'b0, expErr = 1'b0;
  logic [11:0] expData = '0;

  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycle);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rstN) begin
      mMode = modeSel; mPend = 0; mGap = 100000; mAct = 0; mStep = 0; mRiseAt = -1;
      expValid = 0; expErr = 0; expData = '0; mPrevBusy = 1;
    end else begin
      mRise = adcBusy && !mPrevBusy;
      mDec = 0; mDone = 0; mGrant = 0; expValid = 0; expErr = 0;
      if (!mAct) begin
        if (mPend > 0 && mGap >= GAP_OK) mGrant = 1;
      end else begin
        if (mStep == CS - 1) mDec = 1;
        if (mStep >= CS + SL && mRiseAt < 0) begin
          if (mRise) begin
            if (mMode) mRiseAt = mStep;
            else begin expData = adcData; expValid = 1; mDone = 1; end
          end else if (mStep == CS + TMO - 1) begin
            expErr = 1; mDone = 1;
          end
        end else if (mRiseAt >= 0 && mStep == mRiseAt + RD) begin
          expData = adcData; expValid = 1; mDone = 1;
        end
      end
      mGap = mDec ? 0 : (mGap < 100000 ? mGap + 1 : mGap);
      mPend = mPend + int'(sampleReq) - int'(mDec);
      if (mPend > PMAX) mPend = PMAX;
      if (mGrant) begin mAct = 1; mStep = 0; mRiseAt = -1; end
      else if (mDone) mAct = 0;
      else if (mAct) mStep++;
      mPrevBusy = adcBusy;
    end
  end

  // ---------------- converter model and per-cycle compare ----------------
  bit   tbStrobe = 0;
  bit   converting = 0;
  bit   killConv = 0;
  bit   prevConvN = 1;
  int   left = 0;
  int   convLen = 130;
  int   rdLowRun = 0;
  int   rdLowTotal = 0;
  int   validSeen = 0;
  int   riseCycle = 0, validCycle = 0, errCycle = 0;
  int   starts[$];
  logic [11:0] word = POISON;
  logic [11:0] nextWord = 12'h000;

  always @(negedge clk) begin
    if (cycle >= 1) begin
      chk(rstN ? "R2" : "R1", "adcCsN", int'(adcCsN), int'(!mAct));
      chk(rstN ? "R2" : "R1", "adcConvN", int'(adcConvN), int'(!(mAct && mStep >= CS && mStep < CS + SL)));
      chk(mMode ? "R6" : "R5", "adcRdN", int'(adcRdN),
          int'(mMode ? !(mAct && mRiseAt >= 0 && mStep > mRiseAt) : !mAct));
      chk("R5", "resValid", int'(resValid), int'(expValid));
      chk("R7", "resData", int'(resData), int'($signed(expData)));
      chk("R8", "timeoutErr", int'(timeoutErr), int'(expErr));
    end
    if (resValid) begin validSeen++; validCycle = cycle; end
    if (timeoutErr) errCycle = cycle;
    if (!adcRdN) rdLowTotal++;
    if (killConv) begin
      converting = 0; adcBusy = 1; killConv = 0;
    end else if (!converting && prevConvN && !adcConvN && !adcCsN) begin
      converting = 1; left = convLen; adcBusy = 0; starts.push_back(cycle);
    end else if (converting) begin
      left--;
      if (left <= 0) begin
        converting = 0; adcBusy = 1; word = nextWord; riseCycle = cycle;
        nextWord = nextWord + 12'h111;
      end
    end
    prevConvN = adcConvN;
    if (tbStrobe) begin
      rdLowRun = (!adcCsN && !adcRdN) ? rdLowRun + 1 : 0;
      adcData = (rdLowRun >= 2) ? word : POISON;
    end else begin
      adcData = converting ? POISON : word;
    end
  end

  task automatic req();
    @(negedge clk); sampleReq = 1'b1;
    @(negedge clk); sampleReq = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    do begin @(negedge clk); n++; end while (!(resValid || timeoutErr) && n < 3000);
    @(negedge clk);
  endtask

  initial begin
    rstN = 0; modeSel = 0; tbStrobe = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "csN in reset", int'(adcCsN), 1);
    chk("R1", "convN in reset", int'(adcConvN), 1);
    chk("R1", "rdN in reset", int'(adcRdN), 1);
    chk("R1", "valid in reset", int'(resValid), 0);
    chk("R1", "data in reset", int'(resData), 0);
    chk("R1", "err in reset", int'(timeoutErr), 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk("R3", "no conversion without request", int'(adcCsN), 1);

    // always-enabled captures
    nextWord = 12'h7FF; req(); waitDone();
    chk("R7", "word 7FF", int'(resData), 2047);
    chk("R5", "valid one cycle after rise", validCycle - riseCycle, 1);
    nextWord = 12'h800; req(); waitDone();
    chk("R7", "word 800 signed", int'(resData), -2048);
    nextWord = 12'hFFF; req(); waitDone();
    chk("R7", "word FFF signed", int'(resData), -1);

    // queued requests
    repeat (PER) @(negedge clk);
    validSeen = 0; starts.delete(); nextWord = 12'h123;
    req(); req(); req();
    repeat (4 * PER) @(negedge clk);
    chk("R3", "three queued results", validSeen, 3);
    chk("R4", "start count", starts.size(), 3);
    if (starts.size() == 3) begin
      chk("R4", "gap 1", starts[1] - starts[0], PER);
      chk("R4", "gap 2", starts[2] - starts[1], PER);
    end

    // mode input changed after reset
    nextWord = 12'h0F0; req();
    while (adcCsN) @(negedge clk);
    modeSel = 1;
    repeat (CS + 1) @(negedge clk);
    chk("R9", "rdN stays low in always mode", int'(adcRdN), 0);
    waitDone(); modeSel = 0;
    chk("R9", "capture at rise despite mode change", validCycle - riseCycle, 1);

    // timeout
    repeat (PER) @(negedge clk);
    validSeen = 0; starts.delete(); convLen = 100000;
    req();
    waitDone();
    chk("R8", "no valid on timeout", validSeen, 0);
    if (starts.size() == 1) chk("R8", "timeout distance", errCycle - starts[0], TMO);
    chk("R8", "cs released", int'(adcCsN), 1);
    killConv = 1; convLen = 130;
    repeat (PER) @(negedge clk);

    // shared-bus mode
    rstN = 0; modeSel = 1; tbStrobe = 1;
    repeat (4) @(negedge clk);
    rstN = 1; modeSel = 0;
    repeat (2) @(negedge clk);
    nextWord = 12'h001; rdLowTotal = 0; req(); waitDone();
    chk("R6", "word 001", int'(resData), 1);
    chk("R6", "valid after read window", validCycle - riseCycle, RD + 1);
    chk("R6", "read low cycles", rdLowTotal, RD);
    nextWord = 12'hA5A; req(); waitDone();
    chk("R7", "word A5A signed", int'(resData), -1446);
    chk("R9", "strobe mode kept", validCycle - riseCycle, RD + 1);

    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule